// File: doc/BRIEF.md
# SMBus Clock-Control Register Slave

This block is a two-wire serial slave that holds the control bytes of a clock synthesizer. It sits behind an open-drain SCL/SDA pair. Both wires are oversampled with the system clock. A controller can write or read one indexed register, or it can stream the whole bank in ascending order. The register bank drives the synthesizer's output enables, stop masks, power-down drive modes and spread-spectrum enable (register 1 bit 0) as one flat vector. Each register occupies its own byte of `ctrl_o`, with register 0 in bits 7:0.

The slave answers address 0x69, so the write address byte is 0xD2 and the read address byte is 0xD3. The command byte picks the access type. If bit 7 is 1, the access targets a single register and bits 6:0 give its offset. If bit 7 is 0, the access is a block transfer starting at register 0. A block write carries a byte count ahead of its data. A block read returns a byte count ahead of its data.

Register 6 bits 2:0 show the frequency-strap levels supplied on `strap_i`. Register 7 is a fixed identity byte. Neither can be changed over the bus.

Top module: `smb_clkreg_slave`

## Requirements
- R1: After reset, registers 0 to 6 hold FF, FE, FF, 00, 07, 00, 38, with register 6 bits 2:0 replaced by `strap_i`. Register 7 reads 08. SDA is not driven.
- R2: The slave acknowledges an address byte whose upper 7 bits equal 0x69. Any other address gets no acknowledge and changes no register.
- R3: A byte write (command bit 7 = 1, bits 6:0 = offset) stores the data byte in that register, which then appears on `ctrl_o`.
- R4: A byte read (command, repeated START, 0xD3) returns the addressed register MSB first.
- R5: A block write (command 0x00, count byte, data bytes) fills registers from 0 upward. A STOP after any complete byte leaves the higher registers unchanged.
- R6: A block read returns the count value 8 first, then registers 0 through 7, advancing while the master acknowledges.
- R7: Writes to register 6 bits 2:0 and to register 7 are acknowledged but have no effect.
- R8: A data byte aimed at offset 8 or above is not acknowledged and changes no register.
- R9: A block command with nonzero bits 6:0 is not acknowledged.
- R10: A master NACK after a read byte ends the read. SDA is released and stays released.
- R11: A START in any state restarts address reception, discarding a partial byte. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | Data output level when driven, always 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Sampled frequency-strap levels shown in register 6 bits 2:0 |
| ctrl_o | output | 56 | Registers 0 to 6, register k in bits 8k+7:8k |

## Verification
A data write into register 6 and the strap inputs meet in the same register byte. The write updates bits 7:3 in the cycle it commits, while `strap_i` keeps driving bits 2:0. The bench writes register 6 with low bits that differ from the straps and later changes `strap_i` between transfers. It then checks `ctrl_o` and a bus read-back, expecting the written upper field merged with the live strap field. A write commit also lands on the same falling SCL edge that begins the acknowledge. A STOP sent right after that acknowledge must not lose the write, so every write test ends with an immediate STOP and reads the register afterwards.

// File: rtl/smb_clkreg_pkg.sv
package smb_clkreg_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WDATA, ST_ACK, ST_RDATA, ST_MACK
  } smb_st_e;

  function automatic logic [REG_W-1:0] rst_val(int idx);
    case (idx)
      0, 2:    return 8'hFF;
      1:       return 8'hFE;
      4:       return 8'h07;
      6:       return 8'h38;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_clkreg_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter int          STRAP_W  = 3,
  parameter logic [7:0]  ID_VAL   = 8'h08
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [6:0]                    wr_idx_i,
  input  logic [REG_W-1:0]              wr_data_i,
  input  logic [6:0]                    rd_idx_i,
  output logic [REG_W-1:0]              rd_data_o,
  input  logic [STRAP_W-1:0]            strap_i,
  output logic [(NUM_REGS-1)*REG_W-1:0] ctrl_o
);
  localparam int         NUM_RW = NUM_REGS - 1;
  localparam int         SEL_W  = $clog2(NUM_REGS);
  localparam logic [6:0] LIM    = 7'(NUM_REGS);

  logic [REG_W-1:0] regs [NUM_RW];
  logic [REG_W-1:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[g] <= rst_val(g);
      else if (wr_en_i && wr_idx_i == 7'(g)) begin
        if (g == NUM_RW - 1) regs[g] <= {wr_data_i[REG_W-1:STRAP_W], regs[g][STRAP_W-1:0]};
        else                 regs[g] <= wr_data_i;
      end
    end

    if (g == NUM_RW - 1) begin : g_strap
      assign view[g] = {regs[g][REG_W-1:STRAP_W], strap_i};
    end else begin : g_plain
      assign view[g] = regs[g];
    end
    assign ctrl_o[g*REG_W +: REG_W] = view[g];

    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == 7'(g)) |=> $stable(regs[g]));
  end

  assign view[NUM_REGS-1] = ID_VAL;
  assign rd_data_o = (rd_idx_i < LIM) ? view[rd_idx_i[SEL_W-1:0]] : '0;
endmodule

// File: rtl/smb_clkreg_slave.sv
module smb_clkreg_slave
  import smb_clkreg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [7:0] ID_VAL      = 8'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          scl_i,
  input  logic                          sda_i,
  output logic                          sda_o,
  output logic                          sda_oe_o,
  input  logic [STRAP_W-1:0]            strap_i,
  output logic [(NUM_REGS-1)*REG_W-1:0] ctrl_o
);
  localparam logic [6:0] LIM = 7'(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start, stop;
  smb_st_e          state, nxt;
  logic [3:0]       bit_cnt;
  logic [REG_W-1:0] sr, rd_data, tx_byte;
  logic [6:0]       idx;
  logic             send_cnt, ack_q, mack_ok, wr_en, byte_in;

  smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W), .ID_VAL(ID_VAL)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(idx), .wr_data_i(sr),
    .rd_idx_i(idx), .rd_data_o(rd_data), .strap_i, .ctrl_o
  );

  assign byte_in  = scl_fall && bit_cnt == 4'd8;
  assign wr_en    = state == ST_WDATA && byte_in && idx < LIM;
  assign tx_byte  = send_cnt ? 8'(NUM_REGS) : rd_data;
  assign sda_o    = 1'b0;
  assign sda_oe_o = (state == ST_ACK && ack_q) || (state == ST_RDATA && !sr[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; nxt <= ST_IDLE; bit_cnt <= '0; sr <= '0; idx <= '0;
      send_cnt <= 1'b0; ack_q <= 1'b0; mack_ok <= 1'b0;
    end else if (start) begin
      state <= ST_ADDR; bit_cnt <= '0; ack_q <= 1'b0;
    end else if (stop) begin
      state <= ST_IDLE; ack_q <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
          if (scl_rise) begin
            sr      <= {sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_in) begin
            state   <= ST_ACK;
            bit_cnt <= '0;
            ack_q   <= 1'b1;
            nxt     <= ST_WDATA;
            if (state == ST_ADDR) begin
              if (sr[7:1] != SLV_ADDR) begin
                ack_q <= 1'b0; nxt <= ST_IDLE;
              end else if (sr[0]) nxt <= ST_RDATA;
              else                nxt <= ST_CMD;
            end else if (state == ST_CMD) begin
              if (sr[7]) begin
                idx <= sr[6:0]; send_cnt <= 1'b0;
              end else if (sr[6:0] == '0) begin
                idx <= '0; send_cnt <= 1'b1; nxt <= ST_CNT;
              end else begin
                ack_q <= 1'b0; nxt <= ST_IDLE;
              end
            end else if (state == ST_WDATA) begin
              if (idx < LIM) idx <= idx + 7'd1;
              else begin
                ack_q <= 1'b0; nxt <= ST_IDLE;
              end
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          ack_q   <= 1'b0;
          state   <= nxt;
          bit_cnt <= '0;
          if (nxt == ST_RDATA) begin
            sr <= tx_byte;
            if (send_cnt) send_cnt <= 1'b0;
            else          idx <= idx + 7'd1;
          end
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_cnt == 4'd7) begin
            state <= ST_MACK; bit_cnt <= '0;
          end else begin
            sr <= {sr[6:0], 1'b0}; bit_cnt <= bit_cnt + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          else if (scl_fall) begin
            if (mack_ok) begin
              state <= ST_RDATA;
              sr    <= tx_byte;
              if (send_cnt) send_cnt <= 1'b0;
              else          idx <= idx + 7'd1;
            end else state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  p_addr_nack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ADDR && byte_in && !start && !stop && sr[7:1] != SLV_ADDR) |=> !sda_oe_o);
  p_oob_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WDATA && byte_in && idx >= LIM) |=> (state == ST_ACK && !sda_oe_o));
  p_mack_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RDATA && scl_fall && bit_cnt == 4'd7 && !start && !stop) |=> !sda_oe_o);
  p_start_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state == ST_ADDR && bit_cnt == 4'd0));
  p_stop_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state == ST_IDLE && !sda_oe_o));
endmodule

// File: tb/smb_clkreg_slave_tb.sv
module smb_clkreg_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_line, sda_o, sda_oe;
  logic [55:0] ctrl;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_clkreg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .strap_i(strap), .ctrl_o(ctrl)
  );

  typedef struct packed { logic [6:0] off; logic [7:0] wd; logic [7:0] ex; } vec_t;
  localparam vec_t VEC [6] = '{
    '{7'd0, 8'h5A, 8'h5A}, '{7'd3, 8'hC3, 8'hC3}, '{7'd6, 8'hA2, 8'hA5},
    '{7'd7, 8'h55, 8'h08}, '{7'd5, 8'h81, 8'h81}, '{7'd2, 8'h00, 8'h00}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_io(input logic drv, output logic smp);
    sda_m = drv; cw(Q); scl_m = 1'b1; cw(Q); smp = sda_line; cw(Q); scl_m = 1'b0; cw(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cw(Q); scl_m = 1'b1; cw(Q); sda_m = 1'b0; cw(Q); scl_m = 1'b0; cw(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cw(Q); scl_m = 1'b1; cw(Q); sda_m = 1'b1; cw(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
    bit_io(!mack, s);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d,
                            output logic a_cmd, output logic a_dat);
    logic a;
    bus_start(); send_byte(8'hD2, a); send_byte({1'b1, off}, a_cmd);
    send_byte(d, a_dat); bus_stop();
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bus_start(); send_byte(8'hD2, a1); send_byte({1'b1, off}, a2);
    bus_start(); send_byte(8'hD3, a3); recv_byte(1'b0, d); bus_stop();
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic a, b, ok;
    logic [7:0] d;
    cw(5); rst_n = 1'b1; cw(4);

    // R1 reset state
    chk("R1 reset ctrl", 64'(ctrl), 64'h3D_00_07_00_FF_FE_FF);
    chk("R1 sda idle", 64'(sda_oe), 64'h0);
    byte_read(7'd7, d, ok);
    chk("R1 id read", 64'({ok, d}), 64'h108);

    // R3 R4 R7 vector table: byte write then byte read
    foreach (VEC[k]) begin
      byte_write(VEC[k].off, VEC[k].wd, a, b);
      chk("R3 write acks", 64'({a, b}), 64'h3);
      if (VEC[k].off < 7'd7) chk("R3 R7 ctrl field", 64'(ctrl[int'(VEC[k].off)*8 +: 8]), 64'(VEC[k].ex));
      byte_read(VEC[k].off, d, ok);
      chk("R4 R7 readback", 64'({ok, d}), 64'({1'b1, VEC[k].ex}));
    end

    // R7 strap bits follow the input, not the write
    strap = 3'b010; cw(4);
    chk("R7 strap live", 64'(ctrl[55:48]), 64'hA2);
    byte_read(7'd6, d, ok);
    chk("R7 strap read", 64'(d), 64'hA2);

    // R2 foreign address
    bus_start(); send_byte(8'hA0, a); send_byte(8'h80, b); send_byte(8'h11, b); bus_stop();
    chk("R2 foreign nack", 64'(a), 64'h0);
    chk("R2 no change", 64'(ctrl[7:0]), 64'h5A);

    // R5 block write stopped after three data bytes
    bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
    send_byte(8'h11, a); send_byte(8'h22, b); send_byte(8'h33, b); bus_stop();
    chk("R5 block regs", 64'(ctrl[31:0]), 64'hC3_33_22_11);

    // R6 block read: count then registers 0..7
    begin
      logic [7:0] exp_b [9] = '{8'h08, 8'h11, 8'h22, 8'h33, 8'hC3, 8'h07, 8'h81, 8'hA2, 8'h08};
      bus_start(); send_byte(8'hD2, a); send_byte(8'h00, b);
      bus_start(); send_byte(8'hD3, a);
      for (int i = 0; i < 9; i++) begin
        recv_byte(i != 8, d);
        chk("R6 block read byte", 64'(d), 64'(exp_b[i]));
      end
      // R10 released after master NACK
      cw(2 * Q);
      chk("R10 released", 64'({sda_oe, sda_line}), 64'h1);
      bus_stop();
    end

    // R8 out-of-range offset
    byte_write(7'd9, 8'h00, a, b);
    chk("R8 data nack", 64'({a, b}), 64'h2);
    chk("R8 no change", 64'(ctrl), 64'hA2_81_07_C3_33_22_11);

    // R9 bad block command
    bus_start(); send_byte(8'hD2, a); send_byte(8'h05, b); bus_stop();
    chk("R9 cmd nack", 64'(b), 64'h0);

    // R11 START in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) bit_io(1'b1, a);
    bus_start(); send_byte(8'hD2, a); send_byte(8'h84, b); send_byte(8'h3C, b); bus_stop();
    chk("R11 restart write", 64'(ctrl[39:32]), 64'h3C);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule